// File: doc/BRIEF.md
# Two-Port Interrupt Status Aggregator

This block collects event pulses from the logic of two storage ports and turns them into one level-sensitive interrupt line for a host. Each port latches its events into a status byte. Software clears the byte by writing ones. A per-port mask byte decides which events count toward that port's pending flag. The pending flags of both ports, together with a software-settable interrupt bit, feed a host summary register. That register has its own mask and a read-only global flag. The interrupt output is the global flag gated by a global disable bit.

Software reaches the registers over a simple synchronous bus. The bus carries a halfword address, a 16-bit data word and two byte enables, so both byte and halfword writes are possible. Reads are combinational from the address and have no side effects. A host control register holds the global disable, a PHY power-down output and a soft-reset bit. Writing the soft-reset bit starts a small state machine. The machine has two states: `SR_IDLE` and `SR_HOLD`. The transition `SR_IDLE -> SR_HOLD` fires on a soft-reset write. The transition `SR_HOLD -> SR_IDLE` fires after `SRST_CYC` cycles. While in `SR_HOLD`, the machine forces every status and mask to its reset value, and the bit reads back as 1 until the machine returns to `SR_IDLE`.

The expected bring-up order is as follows. First freeze both ports by writing 0xFF to their masks. Then clear the global disable and the host mask bits of the ports. Finally open each port mask, typically to let only the reply-queue and device-interrupt events through (mask 0xCF).

Top module: `irq_aggregator`

## Requirements
- R1: A pulse on a port event input sets the matching status bit on the next edge. Bit 0 = unplug, bit 1 = plug, bit 2 = command complete, bit 3 = fatal error, bit 4 = device interrupt, bit 5 = reply queue not empty. Bit 6 always reads 0.
- R2: A write to the low byte of a port register clears exactly the status bits written as 1. Writing 0xFF clears them all.
- R3: If an event arrives in the same cycle as a write-one-to-clear of the same bit, the bit stays set.
- R4: Port status bit 7 is read-only. It reads 1 when any status bit 5..0 is set while the matching mask bit is 0. A mask of 0xFF (freeze) forces it to 0, and writes to bit 7 have no effect.
- R5: In host status, bit p holds the pending flag of port p, and bit 14 is a software interrupt written through the high byte. Bit 15 is read-only and is the OR of bits 0, 1 and 14 wherever the host mask bit is 0.
- R6: `irq_o` equals host status bit 15 while host control bit 8 (global disable) is 0, and is 0 otherwise.
- R7: After `rst_n`, all port status bits are 0, port masks are 0xFF, the host mask is 0xFFFF, global disable is 1, PHY power-down is 0 and the software interrupt is 0.
- R8: Writing 1 to host control bit 13 starts a soft reset. The bit reads 1 for the 3 cycles after the write edge, then clears itself. The block then holds the R7 values, except that PHY power-down keeps its value. Events and bus writes during the soft reset are ignored.
- R9: `bus_be[0]` and `bus_be[1]` enable the low and high bytes. A port register holds status in its low byte and mask in its high byte. Host control bit 12 drives `phy_pwrdn_o`. Global disable and power-down are written through the high byte.
- R10: The halfword addresses are: 0x00 host control, 0x01 host status, 0x02 host mask, and 0x08 + 4*p for port p. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 7 | Halfword register address |
| bus_be | input | 2 | Byte enables (bit 0 low byte, bit 1 high byte) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| port_evt | input | 12 | Event pulses, port p in bits [6p+5:6p] |
| irq_o | output | 1 | Level interrupt to the host |
| phy_pwrdn_o | output | 1 | PHY power-down request |

## Verification
A directed bring-up sequence checks that a frozen port latches events without raising its pending flag. It then shows that opening the mask to 0xCF separates a masked unplug event from an unmasked reply event. Toggling the global disable shows that it gates only the output line and leaves the summary flag intact. Same-cycle clear and event patterns, and a write to the read-only pending bit, tell set priority apart from clear. A soft reset with events and writes arriving during the hold checks both the hold window and what survives it. Several hundred cycles of seeded random events and byte-enabled writes are then compared against a bench model of every register after each edge.

// File: rtl/irqagg_pkg.sv
`timescale 1ns/1ps
package irqagg_pkg;
    // halfword register addresses
    localparam logic [6:0] A_HCTRL     = 7'h00;
    localparam logic [6:0] A_HSTAT     = 7'h01;
    localparam logic [6:0] A_HMASK     = 7'h02;
    localparam logic [6:0] A_PORT0     = 7'h08;
    localparam int         PORT_STRIDE = 4;

    // host control / status bit positions
    localparam int HC_GDIS   = 8;
    localparam int HC_PHYPD  = 12;
    localparam int HC_SRST   = 13;
    localparam int HS_SOFT   = 14;
    localparam int HS_GLOBAL = 15;
    localparam int PS_PEND   = 7;

    typedef enum logic [0:0] {
        SR_IDLE = 1'b0,
        SR_HOLD = 1'b1
    } srst_state_e;

    function automatic logic [6:0] port_addr(input int p);
        return A_PORT0 + 7'(p * PORT_STRIDE);
    endfunction
endpackage

// File: rtl/irqagg_srst_fsm.sv
`timescale 1ns/1ps
module irqagg_srst_fsm
    import irqagg_pkg::*;
#(
    parameter int HOLD_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    srst_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SR_IDLE: if (start)         state_d = SR_HOLD;
            SR_HOLD: if (cnt_q == LAST) state_d = SR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == SR_HOLD) ? cnt_q + 1'b1 : '0;
        end
    end

    always_comb begin
        busy = (state_q == SR_HOLD);
    end
endmodule

// File: rtl/irqagg_port_regs.sv
`timescale 1ns/1ps
module irqagg_port_regs
    import irqagg_pkg::*;
#(
    parameter int EVW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic [EVW-1:0] evt,
    input  logic           st_we,
    input  logic [EVW-1:0] st_wd,
    input  logic           mk_we,
    input  logic [7:0]     mk_wd,
    output logic [EVW-1:0] st_o,
    output logic [7:0]     mk_o,
    output logic           pend_o,
    output logic [15:0]    rd_o
);
    logic [EVW-1:0] st_q, st_d;
    logic [7:0]     mk_q;

    always_comb begin
        st_d = st_we ? (st_q & ~st_wd) : st_q;
        st_d = st_d | evt;            // set wins over clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            mk_q <= 8'hFF;
        end else if (clr) begin
            st_q <= '0;
            mk_q <= 8'hFF;
        end else begin
            st_q <= st_d;
            if (mk_we) mk_q <= mk_wd;
        end
    end

    always_comb begin
        pend_o = |(st_q & ~mk_q[EVW-1:0]);
        st_o   = st_q;
        mk_o   = mk_q;
        rd_o   = '0;
        rd_o[15:8]     = mk_q;
        rd_o[PS_PEND]  = pend_o;
        rd_o[EVW-1:0]  = st_q;
    end
endmodule

// File: rtl/irqagg_host_regs.sv
`timescale 1ns/1ps
module irqagg_host_regs
    import irqagg_pkg::*;
#(
    parameter int NPORT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ctrl_we,
    input  logic             wd_gdis,
    input  logic             wd_phypd,
    input  logic             stat_we,
    input  logic             wd_soft,
    input  logic [1:0]       mask_we,
    input  logic [15:0]      mask_wd,
    input  logic             srst_busy,
    input  logic [NPORT-1:0] port_pend,
    output logic [15:0]      ctrl_rd,
    output logic [15:0]      stat_rd,
    output logic [15:0]      mask_rd,
    output logic             gdis_o,
    output logic             irq_o,
    output logic             phypd_o
);
    logic        gdis_q, phypd_q, soft_q;
    logic [15:0] hmask_q;
    logic [15:0] raw;
    logic        global_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gdis_q  <= 1'b1;
            phypd_q <= 1'b0;
            soft_q  <= 1'b0;
            hmask_q <= 16'hFFFF;
        end else if (clr) begin
            gdis_q  <= 1'b1;          // power-down deliberately kept
            soft_q  <= 1'b0;
            hmask_q <= 16'hFFFF;
        end else begin
            if (ctrl_we) begin
                gdis_q  <= wd_gdis;
                phypd_q <= wd_phypd;
            end
            if (stat_we)    soft_q        <= wd_soft;
            if (mask_we[0]) hmask_q[7:0]  <= mask_wd[7:0];
            if (mask_we[1]) hmask_q[15:8] <= mask_wd[15:8];
        end
    end

    always_comb begin
        raw = '0;
        raw[NPORT-1:0] = port_pend;
        raw[HS_SOFT]   = soft_q;
        global_pend    = |(raw[14:0] & ~hmask_q[14:0]);
        stat_rd        = raw;
        stat_rd[HS_GLOBAL] = global_pend;
        mask_rd        = hmask_q;
        ctrl_rd        = '0;
        ctrl_rd[HC_GDIS]  = gdis_q;
        ctrl_rd[HC_PHYPD] = phypd_q;
        ctrl_rd[HC_SRST]  = srst_busy;
        gdis_o  = gdis_q;
        phypd_o = phypd_q;
        irq_o   = global_pend & ~gdis_q;
    end
endmodule

// File: rtl/irq_aggregator.sv
`timescale 1ns/1ps
module irq_aggregator
    import irqagg_pkg::*;
#(
    parameter int NPORT    = 2,
    parameter int EVW      = 6,
    parameter int SRST_CYC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [6:0]         bus_addr,
    input  logic [1:0]         bus_be,
    input  logic [15:0]        bus_wdata,
    output logic [15:0]        bus_rdata,
    input  logic [NPORT*EVW-1:0] port_evt,
    output logic               irq_o,
    output logic               phy_pwrdn_o
);
    logic              srst_busy;
    logic              wr_ok;
    logic              hit_ctrl, hit_stat, hit_mask;
    logic              srst_start;
    logic              gdis;
    logic [15:0]       hctrl_rd, hstat_rd, hmask_rd;
    logic [NPORT-1:0]  pend;
    logic [NPORT-1:0]  st_we;
    logic [NPORT-1:0]  mk_we;
    logic [NPORT*EVW-1:0] st_flat;
    logic [NPORT*8-1:0]   mk_flat;
    logic [15:0]       prd [NPORT];

    always_comb begin
        wr_ok      = bus_wr & ~srst_busy;
        hit_ctrl   = (bus_addr == A_HCTRL);
        hit_stat   = (bus_addr == A_HSTAT);
        hit_mask   = (bus_addr == A_HMASK);
        srst_start = wr_ok & hit_ctrl & bus_be[1] & bus_wdata[HC_SRST];
    end

    irqagg_srst_fsm #(.HOLD_CYC(SRST_CYC)) u_srst (
        .clk   (clk),
        .rst_n (rst_n),
        .start (srst_start),
        .busy  (srst_busy)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        localparam logic [6:0] PA = port_addr(g);
        logic hit;
        assign hit      = (bus_addr == PA);
        assign st_we[g] = wr_ok & hit & bus_be[0];
        assign mk_we[g] = wr_ok & hit & bus_be[1];

        irqagg_port_regs #(.EVW(EVW)) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (srst_busy),
            .evt    (port_evt[g*EVW +: EVW]),
            .st_we  (st_we[g]),
            .st_wd  (bus_wdata[EVW-1:0]),
            .mk_we  (mk_we[g]),
            .mk_wd  (bus_wdata[15:8]),
            .st_o   (st_flat[g*EVW +: EVW]),
            .mk_o   (mk_flat[g*8 +: 8]),
            .pend_o (pend[g]),
            .rd_o   (prd[g])
        );
    end

    irqagg_host_regs #(.NPORT(NPORT)) u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (srst_busy),
        .ctrl_we   (wr_ok & hit_ctrl & bus_be[1]),
        .wd_gdis   (bus_wdata[HC_GDIS]),
        .wd_phypd  (bus_wdata[HC_PHYPD]),
        .stat_we   (wr_ok & hit_stat & bus_be[1]),
        .wd_soft   (bus_wdata[HS_SOFT]),
        .mask_we   ({2{wr_ok & hit_mask}} & bus_be),
        .mask_wd   (bus_wdata),
        .srst_busy (srst_busy),
        .port_pend (pend),
        .ctrl_rd   (hctrl_rd),
        .stat_rd   (hstat_rd),
        .mask_rd   (hmask_rd),
        .gdis_o    (gdis),
        .irq_o     (irq_o),
        .phypd_o   (phy_pwrdn_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl) bus_rdata = hctrl_rd;
        if (hit_stat) bus_rdata = hstat_rd;
        if (hit_mask) bus_rdata = hmask_rd;
        for (int p = 0; p < NPORT; p++) begin
            if (bus_addr == port_addr(p)) bus_rdata = prd[p];
        end
    end
endmodule

// File: rtl/irqagg_checker.sv
`timescale 1ns/1ps
module irqagg_checker #(
    parameter int NPORT    = 2,
    parameter int EVW      = 6,
    parameter int HOLD_CYC = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 srst_busy,
    input logic                 gdis,
    input logic                 irq_o,
    input logic                 hsoft,
    input logic [NPORT-1:0]     pend,
    input logic [NPORT-1:0]     st_we,
    input logic [EVW-1:0]       wd,
    input logic [NPORT*EVW-1:0] evt,
    input logic [NPORT*EVW-1:0] st_flat,
    input logic [NPORT*8-1:0]   mk_flat
);
    int busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_run <= 0;
        else        busy_run <= srst_busy ? busy_run + 1 : 0;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_chk
        // R1: an event sets its status bit on the next edge
        p_evt_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (!srst_busy && |evt[p*EVW +: EVW]) |=>
            ((st_flat[p*EVW +: EVW] & $past(evt[p*EVW +: EVW])) == $past(evt[p*EVW +: EVW])));

        // R2: written ones clear, unless an event re-sets them
        p_w1c_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (st_we[p] && !srst_busy) |=>
            ((st_flat[p*EVW +: EVW] & $past(wd & ~evt[p*EVW +: EVW])) == '0));

        // R3: set has priority over clear
        p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (st_we[p] && !srst_busy && |(wd & evt[p*EVW +: EVW])) |=>
            ((st_flat[p*EVW +: EVW] & $past(wd & evt[p*EVW +: EVW])) == $past(wd & evt[p*EVW +: EVW])));

        // R4: a frozen port never reports pending
        p_freeze_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (&mk_flat[p*8 +: 8]) |-> !pend[p]);
    end

    // R6: the line needs a source and an enable
    p_irq_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((|pend || hsoft) && !gdis));

    // R8: hold window bounded by the configured length
    p_srst_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        srst_busy |-> (busy_run < HOLD_CYC));

    // R8: leaving soft reset leaves the reset values behind
    p_srst_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(srst_busy) |-> ((&mk_flat) && gdis && !hsoft && (st_flat == '0)));
endmodule

bind irq_aggregator irqagg_checker #(
    .NPORT(NPORT), .EVW(EVW), .HOLD_CYC(SRST_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .srst_busy (srst_busy),
    .gdis      (gdis),
    .irq_o     (irq_o),
    .hsoft     (hstat_rd[14]),
    .pend      (pend),
    .st_we     (st_we),
    .wd        (bus_wdata[EVW-1:0]),
    .evt       (port_evt),
    .st_flat   (st_flat),
    .mk_flat   (mk_flat)
);

// File: tb/irq_aggregator_bench.sv
`timescale 1ns/1ps
module irq_aggregator_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [11:0] port_evt = '0;
    logic        irq_o, phy_pwrdn_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // bench model
    logic [5:0]  m_st [2];
    logic [7:0]  m_mk [2];
    logic [15:0] m_hmask;
    logic        m_soft, m_gdis, m_phypd;

    always #2 clk = ~clk;

    irq_aggregator u_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .port_evt(port_evt), .irq_o(irq_o), .phy_pwrdn_o(phy_pwrdn_o)
    );

    function automatic logic [6:0] paddr(int p);
        return 7'h08 + 7'(4 * p);
    endfunction

    function automatic logic m_pend(int p);
        return |(m_st[p] & ~m_mk[p][5:0]);
    endfunction

    function automatic logic [15:0] e_port(int p);
        return {m_mk[p], m_pend(p), 1'b0, m_st[p]};
    endfunction

    function automatic logic [15:0] e_hstat();
        logic [15:0] r;
        r = '0;
        r[0] = m_pend(0);
        r[1] = m_pend(1);
        r[14] = m_soft;
        r[15] = |(r[14:0] & ~m_hmask[14:0]);
        return r;
    endfunction

    function automatic logic [15:0] e_ctrl();
        return {3'b000, m_phypd, 3'b000, m_gdis, 8'h00};
    endfunction

    task automatic model_reset(bit keep_pd);
        for (int p = 0; p < 2; p++) begin
            m_st[p] = '0;
            m_mk[p] = 8'hFF;
        end
        m_hmask = 16'hFFFF;
        m_soft  = 1'b0;
        m_gdis  = 1'b1;
        if (!keep_pd) m_phypd = 1'b0;
    endtask

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic rd(logic [6:0] a, output logic [15:0] v);
        bus_addr = a;
        #0.2;
        v = bus_rdata;
    endtask

    task automatic check_all(string tag);
        logic [15:0] v;
        rd(7'h00, v); chk({"R9 ctrl ", tag}, v, e_ctrl());
        rd(7'h01, v); chk({"R5 hstat ", tag}, v, e_hstat());
        rd(7'h02, v); chk({"R10 hmask ", tag}, v, m_hmask);
        rd(paddr(0), v); chk({"R4 port0 ", tag}, v, e_port(0));
        rd(paddr(1), v); chk({"R4 port1 ", tag}, v, e_port(1));
        chk({"R6 irq ", tag}, {15'd0, irq_o}, {15'd0, e_hstat()[15] & ~m_gdis});
        chk({"R9 phy ", tag}, {15'd0, phy_pwrdn_o}, {15'd0, m_phypd});
    endtask

    // one clock with an optional write and event pattern; model follows
    task automatic cyc(bit wr, logic [6:0] a, logic [1:0] be, logic [15:0] wd, logic [11:0] ev);
        bus_wr = wr; bus_addr = a; bus_be = be; bus_wdata = wd; port_evt = ev;
        @(posedge clk);
        #0.5;
        bus_wr = 1'b0; port_evt = '0;
        for (int p = 0; p < 2; p++) begin
            if (wr && a == paddr(p)) begin
                if (be[0]) m_st[p] = m_st[p] & ~wd[5:0];
                if (be[1]) m_mk[p] = wd[15:8];
            end
            m_st[p] = m_st[p] | ev[p*6 +: 6];
        end
        if (wr && a == 7'h00 && be[1]) begin m_gdis = wd[8]; m_phypd = wd[12]; end
        if (wr && a == 7'h01 && be[1]) m_soft = wd[14];
        if (wr && a == 7'h02) begin
            if (be[0]) m_hmask[7:0]  = wd[7:0];
            if (be[1]) m_hmask[15:8] = wd[15:8];
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'h5EED_1622));
        model_reset(0);
        #10;
        rst_n = 1'b1;
        @(negedge clk);
        check_all("reset R7");

        // bring-up: freeze ports, then open global enable and port host bits
        cyc(1, paddr(0), 2'b10, 16'hFF00, '0);
        cyc(1, paddr(1), 2'b10, 16'hFF00, '0);
        cyc(1, 7'h00, 2'b10, 16'h0000, '0);
        cyc(1, 7'h02, 2'b11, 16'hFFFC, '0);
        check_all("bringup");
        // frozen port latches unplug but stays quiet
        cyc(0, 7'h00, 2'b00, 16'h0, 12'h001);
        rd(paddr(0), v); chk("R1 R4 frozen unplug", v, 16'hFF01);
        chk("R4 frozen irq", {15'd0, irq_o}, 16'd0);
        // default mask: only reply and device interrupt pass
        cyc(1, paddr(0), 2'b10, 16'hCF00, '0);
        rd(paddr(0), v); chk("R4 masked unplug", v, 16'hCF01);
        cyc(0, 7'h00, 2'b00, 16'h0, 12'h020);
        rd(paddr(0), v); chk("R1 R4 reply pend", v, 16'hCFA1);
        rd(7'h01, v); chk("R5 hstat port0", v, 16'h8001);
        chk("R6 irq high", {15'd0, irq_o}, 16'd1);
        // port 1 event bits land in its own register
        cyc(0, 7'h00, 2'b00, 16'h0, 12'h3C0);
        rd(paddr(1), v); chk("R1 port1 bits", v, 16'hFF0F);
        // global disable gates only the line
        cyc(1, 7'h00, 2'b10, 16'h0100, '0);
        chk("R6 gdis blocks", {15'd0, irq_o}, 16'd0);
        rd(7'h01, v); chk("R5 summary kept", v, 16'h8001);
        cyc(1, 7'h00, 2'b10, 16'h0000, '0);
        // set beats clear in the same cycle
        cyc(1, paddr(0), 2'b01, 16'h0020, 12'h020);
        rd(paddr(0), v); chk("R3 set wins", v, 16'hCFA1);
        // writes to pending bit are ignored
        cyc(1, paddr(0), 2'b01, 16'h0080, '0);
        rd(paddr(0), v); chk("R4 pend read-only", v, 16'hCFA1);
        // high-byte-only write leaves status
        cyc(1, paddr(0), 2'b10, 16'hCF3F, '0);
        rd(paddr(0), v); chk("R9 byte enable", v, 16'hCFA1);
        cyc(1, paddr(0), 2'b01, 16'h00FF, '0);
        rd(paddr(0), v); chk("R2 clear all", v, 16'hCF00);
        // software interrupt through host mask bit 14
        cyc(1, 7'h01, 2'b10, 16'h4000, '0);
        rd(7'h01, v); chk("R5 soft masked", v, 16'h4000);
        cyc(1, 7'h02, 2'b10, 16'hBF00, '0);
        rd(7'h01, v); chk("R5 soft unmasked", v, 16'hC000);
        chk("R6 soft irq", {15'd0, irq_o}, 16'd1);
        rd(7'h30, v); chk("R10 unmapped", v, 16'h0000);
        check_all("directed");

        // soft reset, power-down kept
        cyc(1, 7'h00, 2'b10, 16'h1000, '0);
        cyc(1, 7'h00, 2'b10, 16'h3000, '0);
        rd(7'h00, v); chk("R8 srst bit set", v & 16'h2000, 16'h2000);
        cyc(0, 7'h00, 2'b00, 16'h0, 12'h004);
        rd(7'h00, v); chk("R8 srst hold 2", v & 16'h2000, 16'h2000);
        cyc(1, paddr(0), 2'b11, 16'h0000, '0);
        rd(7'h00, v); chk("R8 srst hold 3", v & 16'h2000, 16'h2000);
        cyc(0, 7'h00, 2'b00, 16'h0, '0);
        model_reset(1);
        rd(7'h00, v); chk("R8 srst done", v, 16'h1100);
        check_all("after srst R8");

        // seeded random phase
        for (int i = 0; i < 600; i++) begin
            logic [2:0]  op;
            logic [6:0]  a;
            logic [15:0] wd;
            logic [11:0] ev;
            op = 3'($urandom % 6);
            wd = 16'($urandom);
            ev = 12'($urandom) & 12'($urandom) & 12'($urandom);
            unique case (op)
                3'd1: a = paddr(0);
                3'd2: a = paddr(1);
                3'd3: a = 7'h02;
                3'd4: a = 7'h01;
                3'd5: begin a = 7'h00; wd = wd & 16'h1100; end
                default: a = 7'h00;
            endcase
            cyc(op != 0, a, 2'($urandom), op == 0 ? 16'h0 : wd, ev);
            check_all("random R1 R2 R3");
        end

        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule